// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory holding 256 bytes. It watches SCL and SDA, which reach it already synchronised to the system clock. It finds bus START and STOP conditions and decodes the select byte against a fixed 4-bit type code and three strap inputs. It then runs the address, write and read phases. The block only ever pulls SDA low, through an active-high output enable. Reads are served from a register array inside the block. The array resets to all ones.

Each received write byte goes into the array. It is also offered to an external write controller as a one-cycle strobe that carries the address and the data. A STOP that closes a write with data raises a commit strobe. While the controller reports busy, the engine ignores the bus completely. A master can therefore poll the select byte until it is acknowledged again. A random read is a write select plus an address byte, then a repeated START and a read select. The repeated START aborts the current transfer and restarts select decoding.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A select byte, sent MSB first, whose bits 7..4 equal 1010, whose bits 3..1 equal chip_sel_i[2:0] and whose bit 0 is the direction (1 = read) is acknowledged by holding sda_oe_o high through the 9th SCL clock.
- R2: A select byte that fails the match gets no acknowledge. The engine then keeps sda_oe_o low and ignores all traffic until the next START.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Data bits are taken on SCL rising edges. A STOP ends any transfer, and a STOP after only an address byte writes nothing.
- R4: After a write select, the next byte is acknowledged and loads the address counter.
- R5: Each later write byte is acknowledged and stored at the counter, and the counter then increments. The byte is shown for one cycle on wr_valid_o with wr_addr_o and wr_data_o. A STOP after at least one such byte pulses wr_commit_o once.
- R6: A read select is followed by the byte at the counter, sent MSB first (sda_oe_o high means a 0 bit). The counter then increments, so a later current-address read continues from there.
- R7: When the master acknowledges a read byte, the next byte follows. The counter wraps from 0xFF to 0x00 for both reads and writes.
- R8: sda_oe_o is low during the acknowledge slot of every read byte. When the master does not acknowledge, the engine returns to idle and stays off the bus.
- R9: While wr_busy_i is high, sda_oe_o stays low and no START, select byte or data is acted on.
- R10: A repeated START in mid-transfer restarts select decoding and keeps the counter, so that an address write followed by a read select performs a random read.
- R11: After reset, sda_oe_o is low, the counter is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line |
| chip_sel_i | input | 3 | Strap value matched against select bits 3..1 |
| wr_busy_i | input | 1 | External write controller program cycle running |
| sda_oe_o | output | 1 | High pulls SDA low |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 8 | Address of the strobed write byte |
| wr_data_o | output | 8 | Value of the strobed write byte |
| wr_commit_o | output | 1 | One-cycle strobe on a STOP that closes a write with data |

## Verification
The states of the engine can only be seen through the acknowledge and data bits on SDA. A wrong state therefore shows up within one byte time: an acknowledge that is missing or extra in the 9th clock, or a read byte that is shifted or inverted. A corrupt address counter is harder to see. It stays hidden until the next read, so the directed tests always follow a write with a random read and a current-address read, and they cross the 0xFF boundary. The busy, mismatch and NACK cases each clock extra bytes afterwards to show that the bus stays released.

// File: rtl/twi_pkg.sv
package twi_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } twi_state_e;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned STRAP_W  = 3;
   localparam int unsigned BIT_CNT_W = 4;
endpackage

// File: rtl/twi_line_cond.sv
module twi_line_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_o |=> !scl_rise_o);  // R3
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  INIT_BYTE = 8'hFF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [$clog2(DEPTH)-1:0] waddr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [$clog2(DEPTH)-1:0] raddr_i,
   output logic [DATA_W-1:0]        rdata_o
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("twi_mem_array: DEPTH out of range");
   end
   if (DATA_W != 8) begin : g_bad_width
      $error("twi_mem_array: DATA_W must be 8");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= INIT_BYTE[DATA_W-1:0];
      end else if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[raddr_i];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(waddr_i)] == $past(wdata_i)));  // R5

   logic [AW-1:0] unused_aw;
   assign unused_aw = '0;
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
   import twi_pkg::*;
#(
   parameter logic [3:0]  TYPE_CODE = 4'b1010,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_rise_i,
   input  logic                 scl_fall_i,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic                 sda_i,
   input  logic [STRAP_W-1:0]   chip_sel_i,
   input  logic                 wr_busy_i,
   input  logic [BYTE_W-1:0]    rdata_i,
   output logic [ADDR_W-1:0]    addr_o,
   output logic                 sda_oe_o,
   output logic                 wr_valid_o,
   output logic [ADDR_W-1:0]    wr_addr_o,
   output logic [BYTE_W-1:0]    wr_data_o,
   output logic                 wr_commit_o
);
   localparam logic [ADDR_W-1:0]    ADDR_ONE = ADDR_W'(1);
   localparam logic [BIT_CNT_W-1:0] BYTE_END = BIT_CNT_W'(BYTE_W);

   twi_state_e           st;
   logic [BIT_CNT_W-1:0] cnt;
   logic [BYTE_W-1:0]    sh;
   logic [BYTE_W-1:0]    rd_sh;
   logic                 rnw;
   logic                 wrote;
   logic                 m_ack;
   logic                 sel_match;

   assign sel_match = (sh[7:4] == TYPE_CODE) && (sh[3:1] == chip_sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         cnt         <= '0;
         sh          <= '0;
         rd_sh       <= '1;
         rnw         <= 1'b0;
         wrote       <= 1'b0;
         m_ack       <= 1'b0;
         addr_o      <= '0;
         sda_oe_o    <= 1'b0;
         wr_valid_o  <= 1'b0;
         wr_addr_o   <= '0;
         wr_data_o   <= '0;
         wr_commit_o <= 1'b0;
      end else begin
         wr_valid_o  <= 1'b0;
         wr_commit_o <= 1'b0;
         if (wr_busy_i) begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
            wrote    <= 1'b0;
         end else if (start_i) begin
            st       <= ST_DEV;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
            wrote    <= 1'b0;
         end else if (stop_i) begin
            st          <= ST_IDLE;
            sda_oe_o    <= 1'b0;
            wr_commit_o <= wrote;
            wrote       <= 1'b0;
         end else begin
            case (st)
               ST_DEV, ST_ADDR, ST_WDATA: begin
                  if (scl_rise_i) begin
                     sh  <= {sh[BYTE_W-2:0], sda_i};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall_i && cnt == BYTE_END) begin
                     cnt <= '0;
                     if (st == ST_DEV) begin
                        if (sel_match) begin
                           rnw      <= sh[0];
                           sda_oe_o <= 1'b1;
                           st       <= ST_DEV_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_ADDR) begin
                        addr_o   <= sh[ADDR_W-1:0];
                        sda_oe_o <= 1'b1;
                        st       <= ST_ADDR_ACK;
                     end else begin
                        wr_valid_o <= 1'b1;
                        wr_addr_o  <= addr_o;
                        wr_data_o  <= sh;
                        addr_o     <= addr_o + ADDR_ONE;
                        wrote      <= 1'b1;
                        sda_oe_o   <= 1'b1;
                        st         <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall_i) begin
                     cnt <= '0;
                     if (rnw) begin
                        rd_sh    <= rdata_i;
                        sda_oe_o <= ~rdata_i[BYTE_W-1];
                        addr_o   <= addr_o + ADDR_ONE;
                        st       <= ST_RDATA;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_ADDR;
                     end
                  end
               end
               ST_ADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall_i) begin
                     sda_oe_o <= 1'b0;
                     cnt      <= '0;
                     st       <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise_i) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall_i) begin
                     if (cnt == BYTE_END) begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_RACK;
                     end else begin
                        sda_oe_o <= ~rd_sh[BYTE_W-2];
                        rd_sh    <= {rd_sh[BYTE_W-2:0], 1'b1};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise_i) begin
                     m_ack <= ~sda_i;
                  end else if (scl_fall_i) begin
                     if (m_ack) begin
                        rd_sh    <= rdata_i;
                        sda_oe_o <= ~rdata_i[BYTE_W-1];
                        addr_o   <= addr_o + ADDR_ONE;
                        cnt      <= '0;
                        st       <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe_o <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy_i |=> !sda_oe_o);  // R9
   AST_SEL_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV_ACK) |-> sda_oe_o);  // R1
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe_o);  // R2
   AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK) |-> !sda_oe_o);  // R8
   AST_WR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);  // R5
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter logic [3:0]  TYPE_CODE = 4'b1010,
   parameter int unsigned MEM_DEPTH = 256,
   parameter logic [7:0]  INIT_BYTE = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] chip_sel_i,
   input  logic       wr_busy_i,
   output logic       sda_oe_o,
   output logic       wr_valid_o,
   output logic [7:0] wr_addr_o,
   output logic [7:0] wr_data_o,
   output logic       wr_commit_o
);
   localparam int unsigned ADDR_W = $clog2(MEM_DEPTH);

   if (MEM_DEPTH != 256) begin : g_bad_depth
      $error("twi_eeprom_slave: the address byte spans exactly 256 locations");
   end

   logic              scl_rise;
   logic              scl_fall;
   logic              start_c;
   logic              stop_c;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        rdata;

   twi_line_cond i_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_c),
      .stop_o     (stop_c)
   );

   twi_slave_fsm #(
      .TYPE_CODE (TYPE_CODE),
      .ADDR_W    (ADDR_W)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (start_c),
      .stop_i      (stop_c),
      .sda_i       (sda_i),
      .chip_sel_i  (chip_sel_i),
      .wr_busy_i   (wr_busy_i),
      .rdata_i     (rdata),
      .addr_o      (addr),
      .sda_oe_o    (sda_oe_o),
      .wr_valid_o  (wr_valid_o),
      .wr_addr_o   (wr_addr_o),
      .wr_data_o   (wr_data_o),
      .wr_commit_o (wr_commit_o)
   );

   twi_mem_array #(
      .DEPTH     (MEM_DEPTH),
      .DATA_W    (8),
      .INIT_BYTE (INIT_BYTE)
   ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_valid_o),
      .waddr_i (wr_addr_o),
      .wdata_i (wr_data_o),
      .raddr_i (addr),
      .rdata_o (rdata)
   );
endmodule

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;
   localparam time T = 4ns;
   localparam logic [2:0] STRAP = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       wr_busy = 1'b0;
   logic       sda_oe;
   logic       wr_valid;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic       wr_commit;
   wire        sda_line = sda_m & ~sda_oe;

   int n_tests = 0;
   int n_fail  = 0;
   int wv_cnt = 0;
   int commit_cnt = 0;
   int busy_drive = 0;
   logic [7:0] last_a = '0;
   logic [7:0] last_d = '0;
   logic busy_q = 1'b0;
   bit done = 1'b0;

   always #(T/2) clk = ~clk;

   twi_eeprom_slave i_twi_eeprom_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .chip_sel_i  (STRAP),
      .wr_busy_i   (wr_busy),
      .sda_oe_o    (sda_oe),
      .wr_valid_o  (wr_valid),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data),
      .wr_commit_o (wr_commit)
   );

   always @(posedge clk) begin
      busy_q <= wr_busy;
      if (wr_valid) begin
         wv_cnt <= wv_cnt + 1;
         last_a <= wr_addr;
         last_d <= wr_data;
      end
      if (wr_commit) commit_cnt <= commit_cnt + 1;
      if (busy_q && wr_busy && sda_oe) busy_drive <= busy_drive + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sel(input logic rd);
      return {4'b1010, STRAP, rd};
   endfunction

   task automatic bus_start();
      scl_m = 1'b0; #(2*T); sda_m = 1'b1; #(2*T);
      scl_m = 1'b1; #(2*T); sda_m = 1'b0; #(2*T);
   endtask

   task automatic bus_stop();
      scl_m = 1'b0; #(2*T); sda_m = 1'b0; #(2*T);
      scl_m = 1'b1; #(2*T); sda_m = 1'b1; #(2*T);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 1'b0; #(2*T); sda_m = b[i]; #(2*T);
         scl_m = 1'b1; #(4*T);
      end
      scl_m = 1'b0; #(2*T); sda_m = 1'b1; #(2*T);
      scl_m = 1'b1; #(2*T); acked = !sda_line; #(2*T);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit slot_drv);
      for (int i = 7; i >= 0; i--) begin
         scl_m = 1'b0; #(2*T); sda_m = 1'b1; #(2*T);
         scl_m = 1'b1; #(2*T); b[i] = sda_line; #(2*T);
      end
      scl_m = 1'b0; #(2*T); slot_drv = sda_oe; sda_m = !give_ack; #(2*T);
      scl_m = 1'b1; #(4*T);
   endtask

   task automatic t_reset();
      bit a, d; logic [7:0] b;
      chk("R11 sda_oe after reset", int'(sda_oe), 0);
      bus_start();
      send_byte(sel(1'b1), a);
      chk("R1 read select ack", int'(a), 1);
      recv_byte(1'b0, b, d);
      chk("R11 array reset value at addr 0", int'(b), 8'hFF);
      chk("R8 released in ack slot", int'(d), 0);
      bus_stop();
   endtask

   task automatic t_mismatch();
      bit a;
      bus_start();
      send_byte({4'b1010, 3'b011, 1'b0}, a);
      chk("R2 strap mismatch no ack", int'(a), 0);
      send_byte(sel(1'b0), a);
      chk("R2 ignored until START", int'(a), 0);
      bus_stop();
      bus_start();
      send_byte({4'b1011, STRAP, 1'b0}, a);
      chk("R2 type code mismatch no ack", int'(a), 0);
      bus_stop();
      chk("R2 no write strobe", wv_cnt, 0);
   endtask

   task automatic t_write();
      bit a;
      bus_start();
      send_byte(sel(1'b0), a);  chk("R1 write select ack", int'(a), 1);
      send_byte(8'h10, a);      chk("R4 address ack", int'(a), 1);
      send_byte(8'hA5, a);      chk("R5 data ack 1", int'(a), 1);
      chk("R5 first strobe addr", int'(last_a), 8'h10);
      send_byte(8'h3C, a);      chk("R5 data ack 2", int'(a), 1);
      bus_stop();
      #(2*T);
      chk("R5 strobe count", wv_cnt, 2);
      chk("R5 last strobe addr", int'(last_a), 8'h11);
      chk("R5 last strobe data", int'(last_d), 8'h3C);
      chk("R5 commit on STOP", commit_cnt, 1);
   endtask

   task automatic t_random_read();
      bit a, d; logic [7:0] b;
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'h10, a);
      bus_start();
      send_byte(sel(1'b1), a);  chk("R10 select after repeated START", int'(a), 1);
      recv_byte(1'b1, b, d);    chk("R6 first byte", int'(b), 8'hA5);
      chk("R8 slot released", int'(d), 0);
      recv_byte(1'b0, b, d);    chk("R7 sequential byte", int'(b), 8'h3C);
      bus_stop();
      #(2*T);
      chk("R10 dummy write no commit", commit_cnt, 1);
      bus_start();
      send_byte(sel(1'b1), a);
      recv_byte(1'b0, b, d);    chk("R6 current read continues at 0x12", int'(b), 8'hFF);
      bus_stop();
   endtask

   task automatic t_wrap();
      bit a, d; logic [7:0] b;
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'hFF, a);
      send_byte(8'h77, a);
      send_byte(8'h11, a);
      bus_stop();
      #(2*T);
      chk("R7 write counter wraps to 0x00", int'(last_a), 8'h00);
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'hFF, a);
      bus_start();
      send_byte(sel(1'b1), a);
      recv_byte(1'b1, b, d);    chk("R7 byte at 0xFF", int'(b), 8'h77);
      recv_byte(1'b0, b, d);    chk("R7 read wraps to 0x00", int'(b), 8'h11);
      recv_byte(1'b0, b, d);
      chk("R8 bus stays released after NACK", int'(b), 8'hFF);
      chk("R8 no drive in slot after NACK", int'(d), 0);
      bus_stop();
   endtask

   task automatic t_busy();
      bit a, d; logic [7:0] b;
      int wv0 = wv_cnt;
      wr_busy = 1'b1;
      #(2*T);
      bus_start();
      send_byte(sel(1'b0), a);  chk("R9 no ack while busy (write)", int'(a), 0);
      send_byte(8'h55, a);      chk("R9 data ignored while busy", int'(a), 0);
      bus_start();
      send_byte(sel(1'b1), a);  chk("R9 no ack while busy (read)", int'(a), 0);
      recv_byte(1'b0, b, d);    chk("R9 no read data while busy", int'(b), 8'hFF);
      chk("R9 sda_oe never high while busy", busy_drive, 0);
      chk("R9 no write strobe while busy", wv_cnt, wv0);
      wr_busy = 1'b0;
      bus_stop();
      bus_start();
      send_byte(sel(1'b1), a);  chk("R9 ack once idle", int'(a), 1);
      recv_byte(1'b0, b, d);
      bus_stop();
   endtask

   task automatic t_stop_abort();
      bit a, d; logic [7:0] b;
      int wv0 = wv_cnt;
      int c0 = commit_cnt;
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'h20, a);
      bus_stop();
      #(2*T);
      chk("R3 STOP after address: no strobe", wv_cnt, wv0);
      chk("R3 STOP after address: no commit", commit_cnt, c0);
      bus_start();
      send_byte(sel(1'b1), a);
      recv_byte(1'b0, b, d);    chk("R4 counter loaded by address byte", int'(b), 8'hFF);
      bus_stop();
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'h21, a);
      send_byte(8'h5A, a);
      bus_stop();
      bus_start();
      send_byte(sel(1'b1), a);
      recv_byte(1'b0, b, d);    chk("R3 R6 current read at 0x22 after write", int'(b), 8'hFF);
      bus_stop();
      bus_start();
      send_byte(sel(1'b0), a);
      send_byte(8'h21, a);
      bus_start();
      send_byte(sel(1'b1), a);
      recv_byte(1'b0, b, d);    chk("R3 bits sampled on SCL rise", int'(b), 8'h5A);
      bus_stop();
   endtask

   initial begin
      #(100000*T);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      #(4*T);
      rst_n = 1'b1;
      #(4*T);
      t_reset();
      t_mismatch();
      t_write();
      t_random_read();
      t_wrap();
      t_busy();
      t_stop_abort();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule